// File: doc/BRIEF.md
# Parallel One-Dimensional Life Array

This block holds a row of N single-bit cells and advances the whole row by one generation of one-dimensional Life in a single clock cycle. A cell's next value depends on the cell itself and on the two cells on each side of it. The neighbour count is the number of live cells among those four side cells; the centre cell is not counted. A live cell stays alive when the count is 4 or 2. A dead cell comes alive when the count is 3 or 2. In every other case the cell becomes 0.

Every cell is updated from the previous row, never from a value already updated in the same generation. Positions beyond either end of the row always read as 0.

A seed pattern enters through a valid/ready load port. The array accepts a load in any cycle, so `load_ready` is held high and a load never waits. A load takes priority over a step strobe in the same cycle. The current row is always visible on `cells`. A generation counter reports how many steps have been taken since the last load.

Top module: `life1d_array`

## Requirements
- R1: After reset, every bit of `cells` is 0 and `gen_count` is 0.
- R2: When `load_valid` is high at a clock edge, `cells` equals `load_data` after that edge, and `gen_count` is 0.
- R3: When `load_valid` and `step` are both high at the same edge, the load wins: `cells` takes `load_data` and `gen_count` clears.
- R4: On a step, a cell that holds 1 keeps 1 only if its neighbour count is 2 or 4. Otherwise it becomes 0.
- R5: On a step, a cell that holds 0 becomes 1 only if its neighbour count is 2 or 3. Otherwise it stays 0.
- R6: On a step, every cell's new value is computed from the row as it stood before that edge.
- R7: Positions outside bits 0..N-1 count as 0. Cell i's neighbours are bits i-2, i-1, i+1 and i+2.
- R8: With neither `load_valid` nor `step` high, `cells` and `gen_count` keep their values.
- R9: Each step without a load adds 1 to `gen_count`, modulo 2^CNT_W.
- R10: `load_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance the row by one generation |
| load_valid | input | 1 | A seed pattern is offered on `load_data` |
| load_ready | output | 1 | The array accepts a load (always 1) |
| load_data | input | N | Seed pattern; bit i goes to cell i |
| cells | output | N | Current generation |
| gen_count | output | CNT_W | Steps taken since the last load |

## Verification
The hardest cases to reach from the ports are the ones that depend on the ends of the row and on the counter wrapping. Both edge cells see a truncated neighbourhood. The bench therefore seeds patterns with live cells in bits 0, 1, N-2 and N-1 and steps them several times, so that births and deaths at the edges occur. To reach the wrap, the counter is narrowed to 4 bits and the bench steps more than 16 times without a load. A load and a step in the same cycle is driven on purpose, while the row is mid-evolution.

// File: rtl/life1d_pkg.sv
package life1d_pkg;

  // Next state of one cell, given its own bit and the live count of its four side cells.
  function automatic logic life_next(input logic alive, input logic [2:0] nbr_cnt);
    logic res;
    if (alive) res = (nbr_cnt == 3'd2) || (nbr_cnt == 3'd4);
    else       res = (nbr_cnt == 3'd2) || (nbr_cnt == 3'd3);
    return res;
  endfunction

endpackage

// File: rtl/life1d_cell_rule.sv
module life1d_cell_rule
  import life1d_pkg::*;
(
  input  logic       self_bit,
  input  logic [3:0] side_bits,
  output logic       next_bit
);
  logic [2:0] cnt;

  always_comb begin
    cnt = 3'd0;
    for (int k = 0; k < 4; k++) cnt = cnt + {2'b00, side_bits[k]};
    next_bit = life_next(self_bit, cnt);
  end
endmodule

// File: rtl/life1d_gen_counter.sv
module life1d_gen_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R9: an increment without a clear adds exactly one, wrapping at the width
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> count == $past(count) + 1'b1);
  // R2: a clear leaves zero
  a_r2_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/life1d_array.sv
module life1d_array #(
  parameter int N     = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [N-1:0]     load_data,
  output logic [N-1:0]     cells,
  output logic [CNT_W-1:0] gen_count
);
  localparam int REACH = 2;
  localparam int PW    = N + 2 * REACH;

  logic [N-1:0]  row_q;
  logic [N-1:0]  row_next;
  logic [PW-1:0] padded;

  // Zero guard cells at both ends; cell i sits at padded[i+REACH].
  assign padded = {{REACH{1'b0}}, row_q, {REACH{1'b0}}};

  for (genvar i = 0; i < N; i++) begin : g_cell
    life1d_cell_rule u_rule (
      .self_bit  (padded[i+REACH]),
      .side_bits ({padded[i+REACH+2], padded[i+REACH+1], padded[i+REACH-1], padded[i+REACH-2]}),
      .next_bit  (row_next[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          row_q <= '0;
    else if (load_valid) row_q <= load_data;
    else if (step)       row_q <= row_next;
  end

  life1d_gen_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_valid),
    .inc   (step && !load_valid),
    .count (gen_count)
  );

  assign load_ready = 1'b1;
  assign cells      = row_q;

  // R2 R3: a load overrides everything else
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> cells == $past(load_data));
  // R8: no load and no step means the row and the count are frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && !step) |=> ($stable(cells) && $stable(gen_count)));
  // R10: the load port never back-pressures
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n) load_ready);
  // R4 R5: an all-zero row stays all zero on a step (no birth from count 0)
  a_r5_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_valid && cells == '0) |=> cells == '0);
endmodule

// File: tb/sim_life1d_array.sv
module sim_life1d_array;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic load_valid = 1'b0;
  logic load_ready;
  logic [N-1:0]  load_data = '0;
  logic [N-1:0]  cells;
  logic [CW-1:0] gen_count;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [N-1:0]  c;
    logic [CW-1:0] g;
    string         req;
  } item_t;
  item_t q[$];

  logic [N-1:0]  exp_c = '0;
  logic [CW-1:0] exp_g = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  life1d_array #(.N(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .cells(cells), .gen_count(gen_count)
  );

  // Reference generation from the written rule, with zeros beyond both ends.
  function automatic logic [N-1:0] model(input logic [N-1:0] r);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) begin
      int s = 0;
      for (int d = -2; d <= 2; d++) begin
        if (d != 0 && i + d >= 0 && i + d < N) s += int'(r[i+d]);
      end
      if (r[i]) o[i] = (s == 2) || (s == 4);
      else      o[i] = (s == 2) || (s == 3);
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    ntests++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic drive(input logic ld, input logic st, input logic [N-1:0] d, input string req);
    item_t it;
    @(negedge clk);
    load_valid = ld; step = st; load_data = d;
    if (ld) begin exp_c = d; exp_g = '0; end
    else if (st) begin exp_c = model(exp_c); exp_g = exp_g + 1'b1; end
    it.c = exp_c; it.g = exp_g; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compare one queued item per cycle, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.req, " cells"}, 64'(cells), 64'(it.c));
        check({it.req, " gen_count"}, 64'(gen_count), 64'(it.g));
        check("R10 load_ready", 64'(load_ready), 64'd1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 reset cells", 64'(cells), 64'd0);
    check("R1 reset gen_count", 64'(gen_count), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    check("R10 ready after reset", 64'(load_ready), 64'd1);

    // R8: idle cycle with data on the bus has no effect
    drive(1'b0, 1'b0, 16'hFFFF, "R8 idle ignore");
    // R2: load a three-cell seed
    drive(1'b1, 1'b0, 16'h0007, "R2 load");
    // R4 R5 R7: 0007 -> 000F -> 0019 (edge cell 0 survives with count 2)
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, 16'h0000, "R4 R5 R7 step");
    drive(1'b0, 1'b0, 16'hAAAA, "R8 hold");
    // R6 R7: live cells on both ends
    drive(1'b1, 1'b0, 16'hC003, "R2 load edges");
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b1, 16'h0000, "R6 R7 edge step");
    // R4: survival on count 4 in a solid block, R5: births beside it
    drive(1'b1, 1'b0, 16'h03E0, "R2 load block");
    for (int k = 0; k < 6; k++) drive(1'b0, 1'b1, 16'h0000, "R4 R5 R6 block step");
    // R3: load and step together in mid evolution
    drive(1'b1, 1'b1, 16'h2D4B, "R3 load beats step");
    // R9: run past the counter wrap
    for (int k = 0; k < 18; k++) drive(1'b0, 1'b1, 16'h0000, "R9 wrap step");
    drive(1'b0, 1'b0, 16'h0000, "R8 hold after wrap");
    drive(1'b1, 1'b0, 16'h0000, "R2 clear");
    drive(1'b0, 1'b1, 16'h0000, "R5 empty row step");
    drive(1'b0, 1'b0, 16'h0000, "R8 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule